// File: doc/BRIEF.md
# General-Purpose Pin Port with SPI Pin Takeover

An eight-bit pin port for a microcontroller-style chip. Software sees two registers on a plain register bus: an output latch and a direction register. Each pin drives three pad signals: the output value, the output enable, and the level sampled from the pad. A pad level passes through a two-stage synchronizer before any logic uses it.

Two pins can be taken over by an SPI peripheral that sits outside this block. Its enable bit, its master-mode bit and its slave-mode MISO drive signals arrive as plain inputs. Pin 1 (MISO) belongs to the SPI whenever the SPI is enabled. Pin 0 (slave select) belongs to the SPI only when the SPI is enabled and is not the master; in that case it is an input.

While a pin is owned by the SPI, its direction bit does not control the pad. The direction bit still picks the read-back source for that pin. Writes to the output latch take effect while a pin is an input. Software can therefore preload a value and then turn the driver on without a glitch.

Top module: `pin_port`

## Requirements
- R1: After reset, the output latch and the direction register both read 0, and with the SPI disabled every output enable is low.
- R2: On a pin owned by the port, a direction bit of 1 sets that pin's output enable and puts the latched bit on its output value. A direction bit of 0 clears its output enable.
- R3: The direction register is at offset 0x7. All eight bits can be written and read back.
- R4: The output latch is at offset 0x3 and takes every write, whatever the direction. If a pin was preloaded while it was an input, setting its direction bit puts the preloaded value on the pad at once. Latch writes never change the direction register.
- R5: A read of offset 0x3 returns, for each bit, the latched bit when its direction bit is 1 and the synchronized pad level when it is 0. This holds on SPI-owned pins too. A pad change appears in the read-back after two rising clock edges.
- R6: While the SPI enable input is high, bit 1 takes its output enable from the SPI's MISO drive-enable input and its output value from the SPI's MISO drive-value input. Its direction bit then has no effect on the pad.
- R7: While the SPI enable input is high and the master-mode input is low, bit 0 has its output enable held low whatever its direction bit. If either condition fails, bit 0 follows its direction bit like any port-owned pin.
- R8: Reads of any offset other than 0x3 or 0x7 return 0. Writes to such offsets change neither register.
- R9: The synchronized levels of pins 0 and 1 are provided to the SPI on dedicated outputs, with the same two-edge delay as the read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register offset |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the offset |
| spiEnable | input | 1 | SPI enabled |
| spiMaster | input | 1 | SPI is in master mode |
| misoDrive | input | 1 | SPI slave-mode MISO output value |
| misoDriveEn | input | 1 | SPI slave-mode MISO output enable |
| padIn | input | 8 | Levels sampled from the pads |
| padOut | output | 8 | Output values to the pads |
| padOe | output | 8 | Output enables to the pads |
| spiSsIn | output | 1 | Synchronized level of pin 0, to the SPI |
| spiMisoIn | output | 1 | Synchronized level of pin 1, to the SPI |

## Verification
A direction-register write can land on the same edge as a change in SPI ownership. The pad output enables must then show the new owner at once, while the register still takes the written value for the moment ownership returns. The bench provokes this by changing the enable and master-mode inputs in the same low clock phase as a direction write. It then compares the pad outputs against a model of ownership, and the direction read-back against the written value. Random rounds also combine latch writes with pad changes on pins whose direction bit is clear. Read-back is judged only after the two-edge synchronizer delay.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  // Strobes from the register decode to the datapath
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic rdData;
    logic rdDir;
  } regStrobe_t;
endpackage

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl
  import pin_port_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 3,
  parameter int DIR_OFS  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] DataAddr = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] DirAddr  = ADDR_W'(DIR_OFS);

  logic hitData;
  logic hitDir;

  always_comb begin
    hitData       = (busAddr == DataAddr);
    hitDir        = (busAddr == DirAddr);
    strobe.wrData = busWe & hitData;
    strobe.wrDir  = busWe & hitDir;
    strobe.rdData = hitData;
    strobe.rdDir  = hitDir;
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrData, strobe.wrDir}));                        // R8
endmodule

// File: rtl/pin_port_datapath.sv
module pin_port_datapath
  import pin_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MISO_BIT    = 1,
  parameter int SS_BIT      = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              spiEnable,
  input  logic              spiMaster,
  input  logic              misoDrive,
  input  logic              misoDriveEn,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] padOe,
  output logic              spiSsIn,
  output logic              spiMisoIn
);
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] dirReg;
  logic [DATA_W-1:0] syncStage [SYNC_STAGES];
  logic [DATA_W-1:0] pinLevel;
  logic              misoOwned;
  logic              ssOwned;

  // Register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
    end else begin
      if (strobe.wrData) dataReg <= busWdata;
      if (strobe.wrDir)  dirReg  <= busWdata;
    end
  end

  // Pad input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncStage[0] <= '0;
    else       syncStage[0] <= padIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[s] <= '0;
      else       syncStage[s] <= syncStage[s-1];
    end
  end

  assign pinLevel  = syncStage[SYNC_STAGES-1];
  assign spiSsIn   = pinLevel[SS_BIT];
  assign spiMisoIn = pinLevel[MISO_BIT];

  // Pin ownership
  assign misoOwned = spiEnable;
  assign ssOwned   = spiEnable & ~spiMaster;

  for (genvar i = 0; i < DATA_W; i++) begin : g_pad
    if (i == MISO_BIT) begin : g_miso
      assign padOe[i]  = misoOwned ? misoDriveEn : dirReg[i];
      assign padOut[i] = misoOwned ? misoDrive   : dataReg[i];
    end else if (i == SS_BIT) begin : g_ss
      assign padOe[i]  = ssOwned ? 1'b0 : dirReg[i];
      assign padOut[i] = dataReg[i];
    end else begin : g_plain
      assign padOe[i]  = dirReg[i];
      assign padOut[i] = dataReg[i];
    end
  end

  // Read-back: direction selects latch or pin on every bit
  always_comb begin
    if (strobe.rdData)     busRdata = (dataReg & dirReg) | (pinLevel & ~dirReg);
    else if (strobe.rdDir) busRdata = dirReg;
    else                   busRdata = '0;
  end

  AST_SS_HELD_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    (spiEnable && !spiMaster) |-> !padOe[SS_BIT]);                  // R7
  AST_MISO_FROM_SPI: assert property (@(posedge clk) disable iff (!rstN)
    spiEnable |-> (padOe[MISO_BIT] == misoDriveEn && padOut[MISO_BIT] == misoDrive)); // R6
  AST_LATCH_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrData && !strobe.wrDir) |=> $stable(dirReg));           // R4
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrData && !strobe.wrDir) |=> ($stable(dirReg) && $stable(dataReg))); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rdData && !strobe.rdDir) |-> (busRdata == '0));         // R8
endmodule

// File: rtl/pin_port.sv
module pin_port
  import pin_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int DATA_OFS    = 3,
  parameter int DIR_OFS     = 7,
  parameter int SYNC_STAGES = 2,
  parameter int MISO_BIT    = 1,
  parameter int SS_BIT      = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              spiEnable,
  input  logic              spiMaster,
  input  logic              misoDrive,
  input  logic              misoDriveEn,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] padOe,
  output logic              spiSsIn,
  output logic              spiMisoIn
);
  regStrobe_t strobe;

  pin_port_ctrl #(
    .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .strobe(strobe)
  );

  pin_port_datapath #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
    .MISO_BIT(MISO_BIT), .SS_BIT(SS_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .spiEnable(spiEnable), .spiMaster(spiMaster),
    .misoDrive(misoDrive), .misoDriveEn(misoDriveEn), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .spiSsIn(spiSsIn), .spiMisoIn(spiMisoIn)
  );
endmodule

// File: tb/pin_port_tb_top.sv
module pin_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       spiEnable = 1'b0;
  logic       spiMaster = 1'b0;
  logic       misoDrive = 1'b0;
  logic       misoDriveEn = 1'b0;
  logic [7:0] padIn = '0;
  logic [7:0] padOut;
  logic [7:0] padOe;
  logic       spiSsIn;
  logic       spiMisoIn;

  int checkCount = 0;
  int failCount  = 0;
  logic [7:0] expDir  = '0;
  logic [7:0] expData = '0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .spiEnable(spiEnable),
    .spiMaster(spiMaster), .misoDrive(misoDrive), .misoDriveEn(misoDriveEn),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .spiSsIn(spiSsIn), .spiMisoIn(spiMisoIn)
  );

  function automatic logic [7:0] modelOe(logic [7:0] dir, logic en, logic mst, logic dEn);
    logic [7:0] r = dir;
    if (en) r[1] = dEn;
    if (en && !mst) r[0] = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] modelOut(logic [7:0] dat, logic en, logic drv);
    logic [7:0] r = dat;
    if (en) r[1] = drv;
    return r;
  endfunction

  function automatic logic [7:0] modelRead(logic [3:0] a, logic [7:0] dir,
                                           logic [7:0] dat, logic [7:0] pin);
    if (a == 4'h3) return (dat & dir) | (pin & ~dir);
    if (a == 4'h7) return dir;
    return 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [7:0] v);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = v;
    @(negedge clk);
    busWe = 1'b0;
    if (a == 4'h3) expData = v;
    else if (a == 4'h7) expDir = v;
  endtask

  task automatic readCheck(string req, logic [3:0] a);
    busAddr = a;
    #1;
    check(req, busRdata, modelRead(a, expDir, expData, padIn));
  endtask

  task automatic padCheck(string req);
    check({req, " oe"}, padOe, modelOe(expDir, spiEnable, spiMaster, misoDriveEn));
    check({req, " out"}, padOut, modelOut(expData, spiEnable, misoDrive));
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 oe", padOe, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    busAddr = 4'h7; #1; check("R1 dir", busRdata, 8'h00);
    check("R1 oe after release", padOe, 8'h00);
    // R3: direction register read/write
    busWrite(4'h7, 8'hA5); readCheck("R3", 4'h7);
    busWrite(4'h7, 8'h00); readCheck("R3", 4'h7);
    // R4: preload while input, then enable driver
    busWrite(4'h3, 8'h3C); readCheck("R4 dir untouched", 4'h7);
    check("R4 no drive yet", padOe, 8'h00);
    busWrite(4'h7, 8'hFF);
    padCheck("R4 R2 preload");
    // R5: pin read-back with synchronizer delay
    busWrite(4'h7, 8'h0F);
    padIn = 8'hC3;
    @(posedge clk); @(negedge clk);
    busAddr = 4'h3; #1;
    check("R5 one edge not yet", busRdata, 8'h0C);
    settle(); readCheck("R5 mixed", 4'h3);
    check("R9 ss", {7'b0, spiSsIn}, {7'b0, padIn[0]});
    check("R9 miso", {7'b0, spiMisoIn}, {7'b0, padIn[1]});
    // R8: unmapped offsets
    busWrite(4'h5, 8'hEE); readCheck("R8 read zero", 4'h5);
    readCheck("R8 dir kept", 4'h7); readCheck("R8 data kept", 4'h3);
    // R6, R7: SPI ownership
    busWrite(4'h7, 8'hFF);
    @(negedge clk);
    spiEnable = 1'b1; spiMaster = 1'b0; misoDriveEn = 1'b0; misoDrive = 1'b1; #1;
    padCheck("R6 R7 slave");
    spiMaster = 1'b1; #1; padCheck("R7 master releases ss");
    misoDriveEn = 1'b1; misoDrive = 1'b0; #1; padCheck("R6 drive");
    readCheck("R5 owned pins", 4'h3);
    // Simultaneous: dir write together with ownership change
    @(negedge clk);
    busAddr = 4'h7; busWe = 1'b1; busWdata = 8'h03; spiMaster = 1'b0; misoDriveEn = 1'b0;
    #1; check("R7 same cycle oe", padOe, modelOe(expDir, 1'b1, 1'b0, 1'b0));
    @(negedge clk); busWe = 1'b0; expDir = 8'h03;
    readCheck("R3 same cycle", 4'h7); padCheck("R6 R7 same cycle");
    spiEnable = 1'b0; #1; padCheck("R2 released");
    // Random rounds
    for (int n = 0; n < 300; n++) begin
      logic [3:0] a;
      @(negedge clk);
      padIn = 8'($urandom); spiEnable = 1'($urandom); spiMaster = 1'($urandom);
      misoDrive = 1'($urandom); misoDriveEn = 1'($urandom);
      a = ($urandom % 3 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'h3 : 4'h7);
      busWrite(a, 8'($urandom));
      settle();
      padCheck("R2 R6 R7 random");
      readCheck("R5 random", 4'h3);
      readCheck("R3 random", 4'h7);
      readCheck("R8 random", 4'($urandom));
      check("R9 random", {6'b0, spiMisoIn, spiSsIn}, {6'b0, padIn[1:0]});
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checkCount++; failCount++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule